// File: doc/BRIEF.md
# Rotated Immediate Constant Encoder

This block decides whether a 32-bit constant can be produced by taking an 8-bit value and rotating it right by an even number of bit positions. If it can, the block returns the 12-bit immediate field: the rotate count in the upper four bits and the 8-bit value in the lower eight. When the constant itself has no such form but its bitwise complement does, the block says so and returns the complement's field. A code generator can then load the constant with a move-negated operation, which writes the one's complement of its operand.

A constant is accepted on a valid/ready handshake. The block then tests one rotate count per clock, starting at 0. It stops at the first count whose rotation fits the direct constant, or after all sixteen counts. It raises `done` and holds the result until the next request is accepted. `in_ready` is high whenever no search is running, and that includes while a finished result is being held. A request offered while `in_ready` is low is not taken: the source must keep `in_valid` and `in_data` steady until a cycle in which both handshake signals are high. There is no back-pressure on the result side. The result stays on the outputs until the next request is accepted.

Top module: `rot_imm_encoder`

## Requirements
- R1: After a synchronous active-high reset, which may be applied mid-search, `done`, `found` and `found_inv` are 0 and `in_ready` is 1.
- R2: When the constant K is encodable, `done` rises with `found`=1. `imm[11:8]` holds a count c and `imm[7:0]` holds a byte b such that b rotated right by 2*c over 32 bits equals K.
- R3: When more than one count encodes K, the smallest count is reported. Constants 0 to 255 therefore give c=0, 0xFF000000 gives 0x4FF, and 0x3FC gives 0xFFF.
- R4: When neither K nor ~K is encodable, as with 0x12345678, `done` rises with `found`=0, `found_inv`=0 and `imm`=0.
- R5: When K is not encodable but ~K is, `found`=0 and `found_inv`=1. `imm` holds the smallest-count encoding of ~K. For example, 0xFFFFFFFF gives 0x000.
- R6: `found` and `found_inv` are never both 1; the direct encoding takes priority over the complement.
- R7: `done` rises exactly c+1 cycles after the accepting clock edge when the direct search stops at count c. When no direct encoding exists, it rises 16 cycles after that edge.
- R8: While a search runs, `in_ready` is 0, and `in_valid` has no effect on the result.
- R9: While `done` is high and no request is accepted, `done`, `found`, `found_inv` and `imm` hold their values. The cycle after an accepted request, `done` is 0 and a new search runs on the new constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Constant offered |
| in_ready | output | 1 | Block can accept a constant (no search running) |
| in_data | input | 32 | Constant to encode |
| done | output | 1 | Result valid, held until the next accepted request |
| found | output | 1 | Constant itself is encodable |
| found_inv | output | 1 | Only the complement is encodable |
| imm | output | 12 | Rotate count in [11:8], 8-bit value in [7:0] |

## Verification
The constants tried include:
- small values that fit without rotation;
- bytes placed at several even offsets, including fields that wrap across bit 31 and fields that several counts could encode;
- values spanning more than eight bits;
- near-all-ones words that only their complement reaches.

Comparing the reported count and the number of cycles until `done` against values worked out by hand separates three outcomes: an early stop, a complete search that proves no encoding exists, and a search that only finds the complement. Directed cases offer a request during a search, reset in the middle of a search, hold the result across idle cycles, and restart the block while a result is being held.

// File: rtl/rie_pkg.sv
package rie_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_HOLD = 2'd2
  } scan_state_e;
endpackage

// File: rtl/rie_fit_lane.sv
// Rotates a word left by STEP*cnt and reports whether the result fits the low field.
module rie_fit_lane #(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 8,
  parameter int CNT_W   = 4,
  parameter int STEP    = 2
) (
  input  logic [DATA_W-1:0]  word,
  input  logic [CNT_W-1:0]   cnt,
  output logic               fit,
  output logic [FIELD_W-1:0] field
);
  logic [DATA_W-1:0] rot;
  int unsigned       sh_amt;

  always_comb begin
    sh_amt = 32'(cnt) * 32'(STEP);
    rot    = (word << sh_amt) | (word >> (32'(DATA_W) - sh_amt));
    fit    = ~|rot[DATA_W-1:FIELD_W];
    field  = rot[FIELD_W-1:0];
  end
endmodule

// File: rtl/rie_scan_ctrl.sv
// Sequences the rotate counts and latches the first direct or complement hit.
module rie_scan_ctrl
  import rie_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 8,
  parameter int CNT_W   = 4,
  parameter int STEPS   = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [DATA_W-1:0]          in_data,
  output logic [DATA_W-1:0]          op,
  output logic [CNT_W-1:0]           cnt,
  input  logic                       dir_fit,
  input  logic [FIELD_W-1:0]         dir_field,
  input  logic                       inv_fit,
  input  logic [FIELD_W-1:0]         inv_field,
  output logic                       done,
  output logic                       found,
  output logic                       found_inv,
  output logic [CNT_W+FIELD_W-1:0]   imm
);
  localparam int IMM_W = CNT_W + FIELD_W;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEPS - 1);

  scan_state_e      state;
  logic             inv_hit;
  logic [IMM_W-1:0] inv_imm;
  logic             accept;

  assign in_ready = (state != ST_SCAN);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op        <= '0;
      cnt       <= '0;
      inv_hit   <= 1'b0;
      inv_imm   <= '0;
      done      <= 1'b0;
      found     <= 1'b0;
      found_inv <= 1'b0;
      imm       <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_HOLD: begin
          if (accept) begin
            op        <= in_data;
            cnt       <= '0;
            inv_hit   <= 1'b0;
            inv_imm   <= '0;
            done      <= 1'b0;
            found     <= 1'b0;
            found_inv <= 1'b0;
            imm       <= '0;
            state     <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (dir_fit) begin
            found <= 1'b1;
            imm   <= {cnt, dir_field};
            done  <= 1'b1;
            state <= ST_HOLD;
          end else begin
            if (inv_fit && !inv_hit) begin
              inv_hit <= 1'b1;
              inv_imm <= {cnt, inv_field};
            end
            if (cnt == LAST_CNT) begin
              done      <= 1'b1;
              found_inv <= inv_hit | inv_fit;
              if (inv_hit)      imm <= inv_imm;
              else if (inv_fit) imm <= {cnt, inv_field};
              else              imm <= '0;
              state <= ST_HOLD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rot_imm_encoder.sv
module rot_imm_encoder #(
  parameter int DATA_W   = 32,
  parameter int FIELD_W  = 8,
  parameter int ROT_STEP = 2,
  localparam int STEPS   = DATA_W / ROT_STEP,
  localparam int CNT_W   = $clog2(STEPS),
  localparam int IMM_W   = CNT_W + FIELD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              done,
  output logic              found,
  output logic              found_inv,
  output logic [IMM_W-1:0]  imm
);
  logic [DATA_W-1:0]  op;
  logic [CNT_W-1:0]   cnt;
  logic [DATA_W-1:0]  lane_word [2];
  logic               lane_fit  [2];
  logic [FIELD_W-1:0] lane_field[2];

  assign lane_word[0] = op;
  assign lane_word[1] = ~op;

  // lane 0 tests the constant, lane 1 its complement
  for (genvar g = 0; g < 2; g++) begin : g_lane
    rie_fit_lane #(
      .DATA_W(DATA_W), .FIELD_W(FIELD_W), .CNT_W(CNT_W), .STEP(ROT_STEP)
    ) u_lane (
      .word (lane_word[g]),
      .cnt  (cnt),
      .fit  (lane_fit[g]),
      .field(lane_field[g])
    );
  end

  rie_scan_ctrl #(
    .DATA_W(DATA_W), .FIELD_W(FIELD_W), .CNT_W(CNT_W), .STEPS(STEPS)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .op       (op),
    .cnt      (cnt),
    .dir_fit  (lane_fit[0]),
    .dir_field(lane_field[0]),
    .inv_fit  (lane_fit[1]),
    .inv_field(lane_field[1]),
    .done     (done),
    .found    (found),
    .found_inv(found_inv),
    .imm      (imm)
  );
endmodule

// File: rtl/rot_imm_encoder_chk.sv
module rot_imm_encoder_chk #(
  parameter int DATA_W   = 32,
  parameter int FIELD_W  = 8,
  parameter int ROT_STEP = 2,
  localparam int STEPS   = DATA_W / ROT_STEP,
  localparam int CNT_W   = $clog2(STEPS),
  localparam int IMM_W   = CNT_W + FIELD_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              done,
  input logic              found,
  input logic              found_inv,
  input logic [IMM_W-1:0]  imm
);
  localparam int WC_W = CNT_W + 2;

  logic [DATA_W-1:0] k_q;
  logic [WC_W-1:0]   wait_cnt;

  function automatic logic [DATA_W-1:0] rotr_f(logic [DATA_W-1:0] v, int unsigned s);
    return (v >> s) | (v << (32'(DATA_W) - s));
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      k_q      <= '0;
      wait_cnt <= '0;
    end else if (in_valid && in_ready) begin
      k_q      <= in_data;
      wait_cnt <= '0;
    end else if (!done && !in_ready && wait_cnt != '1) begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    done |-> !(found && found_inv));

  a_r2_direct_decodes: assert property (@(posedge clk) disable iff (rst)
    (done && found) |->
      rotr_f(DATA_W'(imm[FIELD_W-1:0]), 32'(imm[IMM_W-1:FIELD_W]) * ROT_STEP) == k_q);

  a_r5_inverse_decodes: assert property (@(posedge clk) disable iff (rst)
    (done && found_inv) |->
      rotr_f(DATA_W'(imm[FIELD_W-1:0]), 32'(imm[IMM_W-1:FIELD_W]) * ROT_STEP) == ~k_q);

  a_r4_empty_field: assert property (@(posedge clk) disable iff (rst)
    (done && !found && !found_inv) |-> imm == '0);

  a_r7_latency_bound: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (wait_cnt >= 1 && wait_cnt <= WC_W'(STEPS)));

  a_r8_busy_not_done: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> !done);

  a_r9_accept_clears: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (!done && !in_ready));

  a_r9_result_holds: assert property (@(posedge clk) disable iff (rst)
    (done && !in_valid) |=>
      (done && $stable(found) && $stable(found_inv) && $stable(imm)));
endmodule

bind rot_imm_encoder rot_imm_encoder_chk #(
  .DATA_W(DATA_W), .FIELD_W(FIELD_W), .ROT_STEP(ROT_STEP)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_data  (in_data),
  .done     (done),
  .found    (found),
  .found_inv(found_inv),
  .imm      (imm)
);

// File: tb/sim_rot_imm_encoder.sv
`timescale 1ns/1ps
module sim_rot_imm_encoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        done;
  logic        found;
  logic        found_inv;
  logic [11:0] imm;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  rot_imm_encoder u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .done(done), .found(found), .found_inv(found_inv), .imm(imm)
  );

  localparam int NV = 14;
  // constant, expected imm, expected {found, found_inv}, expected latency
  localparam logic [31:0] V_K [NV] = '{
    32'h00000000, 32'h000000FF, 32'h000000AB, 32'hFF000000, 32'h000003FC,
    32'h000003C0, 32'h12345678, 32'hFFFFFFFF, 32'hFFFFFF00, 32'h00FFFFFF,
    32'h00000101, 32'hC000003F, 32'h00AB0000, 32'h00000100};
  localparam logic [11:0] V_IMM [NV] = '{
    12'h000, 12'h0FF, 12'h0AB, 12'h4FF, 12'hFFF,
    12'hD0F, 12'h000, 12'h000, 12'h0FF, 12'h4FF,
    12'h000, 12'h1FF, 12'h8AB, 12'hC01};
  localparam logic [1:0] V_FL [NV] = '{
    2'b10, 2'b10, 2'b10, 2'b10, 2'b10,
    2'b10, 2'b00, 2'b01, 2'b01, 2'b01,
    2'b00, 2'b10, 2'b10, 2'b10};
  localparam int V_LAT [NV] = '{
    1, 1, 1, 5, 16, 14, 16, 16, 16, 16, 16, 2, 9, 13};

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  // offer k, return cycles from accepting edge until done is seen
  task automatic run(input logic [31:0] k, output int lat);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = k;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lat;
    string tag;
    rst = 1'b1;
    in_valid = 1'b0;
    in_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "done", 32'(done), 0);
    check("R1", "in_ready", 32'(in_ready), 1);
    check("R1", "flags", 32'({found, found_inv}), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run(V_K[i], lat);
      tag = (V_FL[i] == 2'b10) ? "R2 R3" : (V_FL[i] == 2'b01) ? "R5" : "R4";
      check(tag, $sformatf("flags k=%h", V_K[i]), 32'({found, found_inv}), 32'(V_FL[i]));
      check(tag, $sformatf("imm k=%h", V_K[i]), 32'(imm), 32'(V_IMM[i]));
      check("R7", $sformatf("latency k=%h", V_K[i]), 32'(lat), 32'(V_LAT[i]));
      check("R6", "exclusive flags", 32'(found && found_inv), 0);
    end

    // R9 hold: result stays across idle cycles
    repeat (5) @(negedge clk);
    check("R9", "held done", 32'(done), 1);
    check("R9", "held imm", 32'(imm), 32'h0C01);

    // R8: offer a request mid-search, it must be ignored
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 32'h12345678;
    @(negedge clk);
    in_data  = 32'h000000AB;
    @(negedge clk);
    check("R8", "in_ready busy", 32'(in_ready), 0);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R8", "ignored request flags", 32'({found, found_inv}), 0);
    check("R8", "ignored request imm", 32'(imm), 0);

    // R9 restart while holding: done drops the cycle after acceptance
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 32'hFF000000;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", "done cleared on restart", 32'(done), 0);
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R9", "restart imm", 32'(imm), 32'h4FF);

    // R1 reset mid-search
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 32'h12345678;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "mid-search reset done", 32'(done), 0);
    check("R1", "mid-search reset ready", 32'(in_ready), 1);
    check("R1", "mid-search reset flags", 32'({found, found_inv}), 0);

    finish_run();
  end
endmodule